// File: doc/BRIEF.md
# Full-Scan Test Sequencer

The block is a self-contained scan test controller that drives a small full-scan circuit built into it. The circuit under test is a chain of `CHAIN` scan flip-flops wrapped around a fixed piece of example combinational logic. Each flip-flop has a two-way select at its D input: it takes either the previous stage (shift) or the functional next-state value (capture). The controller drives the scan-mode select, the serial scan input and the primary-input lines. It watches the serial scan output and the primary outputs, and compares them with the expected responses that the user presents on its input buses.

A run starts with one pulse on `start_i`. The first phase is a flush pass, which streams a known pattern through the chain so that the flip-flops and their shift path are proven before any vector is used. The vectors then follow in order. Each vector is shifted in, its primary inputs are applied, and the primary outputs are compared in the single capture cycle, which also loads the combinational response into the chain. Unloading one response shares its shift cycles with loading the next vector. A final unload, with zero shifted in, retrieves the last response. Because of this overlap the vector phase always lasts `NVEC*(CHAIN+1)+CHAIN` cycles.

Any mismatch raises a sticky fail flag and records the index of the first failing vector. The `done_o` output rises after the final unload.

Top module: `fscan_seq`

## Requirements
- R1: After reset `done_o`=0, `fail_o`=0, `fail_vec_o`=0 and `scan_mode_o`=1 (idle shifting).
- R2: A start accepted while idle begins a flush of 2*CHAIN cycles. Throughout the flush `scan_mode_o`=1, and in flush cycle k (0-based) `scan_in_o` is bit 1 of k, giving the pattern 0,0,1,1,... From cycle CHAIN onward, `scan_out_o` must equal the bit driven CHAIN cycles earlier. A flush mismatch records index NVEC.
- R3: Each vector v (bits `vec_state_i[v*CHAIN +: CHAIN]`) is loaded in CHAIN cycles with `scan_mode_o`=1. In load cycle k, `scan_in_o` carries vector bit CHAIN-1-k, so vector bit i ends in chain stage i, and stage 0 is next to the scan input.
- R4: Each load is followed by exactly one cycle with `scan_mode_o`=0. In that cycle `pi_o` equals `vec_pi_i[v*PIW +: PIW]` and `po_o` is compared with `exp_po_i[v*POW +: POW]`. At the end of the cycle the chain takes the functional next state.
- R5: While vector v≥1 loads, `scan_out_o` in cycle k is compared with bit CHAIN-1-k of the expected state of vector v-1 (`exp_state_i[(v-1)*CHAIN +: CHAIN]`). After the last capture, a final unload of CHAIN cycles drives `scan_in_o`=0 and compares against the expected state of vector NVEC-1.
- R6: `done_o` becomes 1 at the edge that ends cycle 2*CHAIN + NVEC*(CHAIN+1) + CHAIN, counted from the edge that accepted start, and a run holds exactly NVEC capture cycles.
- R7: The first mismatch sets `fail_o` and stores its vector index in `fail_vec_o`. A capture-cycle mismatch stores v, and a scan-out mismatch stores the vector whose response was being unloaded. Later mismatches change neither output until the next start.
- R8: `start_i` while a run is in progress has no effect on its length or results. `done_o` holds until the next accepted start, and that start clears `done_o`, `fail_o` and `fail_vec_o`.
- R9: The example logic, with state s, inputs p and N=CHAIN: next[i] = s[(i+N-1)%N] ^ (s[i] & s[(i+1)%N]) ^ p[i%PIW]; po[j] = s[(2j)%N] ^ (s[(2j+1)%N] & p[j%PIW]).
- R10: With scan mode 1, every stage i>0 takes stage i-1 and stage 0 takes `scan_in_o`. With scan mode 0, every stage takes its functional next state. `scan_out_o` is stage CHAIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when idle |
| vec_state_i | input | NVEC*CHAIN | Scan state of each vector, vector v at bits v*CHAIN |
| vec_pi_i | input | NVEC*PIW | Primary inputs of each vector |
| exp_state_i | input | NVEC*CHAIN | Expected captured state of each vector |
| exp_po_i | input | NVEC*POW | Expected primary outputs of each vector |
| scan_mode_o | output | 1 | Scan-mode select applied to the chain |
| scan_in_o | output | 1 | Serial data applied to chain stage 0 |
| scan_out_o | output | 1 | Serial data from the last chain stage |
| pi_o | output | PIW | Primary inputs applied to the logic |
| po_o | output | POW | Primary outputs of the logic |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_vec_o | output | $clog2(NVEC+1) | Index of the first failing vector (NVEC for flush) |

## Verification
The assertions guard the following on every cycle:
- the shift and capture behaviour of the chain stages;
- that a capture lasts one cycle;
- that a load begins only after a flush or a capture;
- that the fail flag and its index stay unchanged until a new start;
- that done appears only while idle.

Only the bench scenarios can show the rest:
- the serial ordering of the flush, load and unload bits;
- the exact cycle at which done rises;
- that the first failure index wins over later mismatches;
- that a start during a run is ignored;
- that the example logic matches its stated functions.

// File: rtl/fscan_pkg.sv
package fscan_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FLUSH  = 3'd1,
        PH_LOAD   = 3'd2,
        PH_CAPT   = 3'd3,
        PH_UNLOAD = 3'd4
    } phase_e;
endpackage

// File: rtl/fscan_logic.sv
module fscan_logic #(
    parameter int CHAIN = 8,
    parameter int PIW   = 4,
    parameter int POW   = 4
) (
    input  logic [CHAIN-1:0] state_i,
    input  logic [PIW-1:0]   pi_i,
    output logic [CHAIN-1:0] next_o,
    output logic [POW-1:0]   po_o
);
    // functional next state of every stage (R9)
    for (genvar i = 0; i < CHAIN; i++) begin : g_next
        assign next_o[i] = state_i[(i + CHAIN - 1) % CHAIN]
                         ^ (state_i[i] & state_i[(i + 1) % CHAIN])
                         ^ pi_i[i % PIW];
    end

    // primary outputs (R9)
    for (genvar j = 0; j < POW; j++) begin : g_po
        assign po_o[j] = state_i[(2 * j) % CHAIN]
                       ^ (state_i[(2 * j + 1) % CHAIN] & pi_i[j % PIW]);
    end
endmodule

// File: rtl/fscan_chain.sv
module fscan_chain #(
    parameter int CHAIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_mode_i,
    input  logic             sdi_i,
    input  logic [CHAIN-1:0] func_i,
    output logic [CHAIN-1:0] state_o
);
    logic [CHAIN-1:0] chain_d;
    logic [CHAIN-1:0] chain_q;

    // one select per stage: shift path or functional data (R10)
    for (genvar i = 0; i < CHAIN; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign chain_d[i] = scan_mode_i ? sdi_i : func_i[i];
        end else begin : g_body
            assign chain_d[i] = scan_mode_i ? chain_q[i-1] : func_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign state_o = chain_q;

    p_shift_body_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mode_i |=> chain_q[CHAIN-1:1] == $past(chain_q[CHAIN-2:0]));
    p_shift_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mode_i |=> chain_q[0] == $past(sdi_i));
    p_capture_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_mode_i |=> chain_q == $past(func_i));
endmodule

// File: rtl/fscan_ctrl.sv
module fscan_ctrl
    import fscan_pkg::*;
#(
    parameter int CHAIN = 8,
    parameter int NVEC  = 6,
    parameter int PIW   = 4,
    parameter int POW   = 4,
    localparam int VW   = $clog2(NVEC + 1),
    localparam int VIW  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int CW   = $clog2(2 * CHAIN),
    localparam int KW   = $clog2(CHAIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [NVEC*CHAIN-1:0] vec_state_i,
    input  logic [NVEC*PIW-1:0]   vec_pi_i,
    input  logic [NVEC*CHAIN-1:0] exp_state_i,
    input  logic [NVEC*POW-1:0]   exp_po_i,
    input  logic                  sdo_i,
    input  logic [POW-1:0]        po_i,
    output logic                  scan_mode_o,
    output logic                  sdi_o,
    output logic [PIW-1:0]        pi_o,
    output logic                  done_o,
    output logic                  fail_o,
    output logic [VW-1:0]         fail_vec_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CW-1:0]    cnt;
        logic [VIW-1:0]   vidx;
        logic             fail;
        logic [VW-1:0]    fidx;
        logic             done;
    } ctrl_t;

    ctrl_t r_q, r_d;

    // per-vector views; scan bits stored in shift order (index k = bit CHAIN-1-k)
    logic           vec_sh [NVEC][CHAIN];
    logic           exp_sh [NVEC][CHAIN];
    logic [PIW-1:0] pi_arr [NVEC];
    logic [POW-1:0] po_arr [NVEC];

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        assign pi_arr[v] = vec_pi_i[v*PIW +: PIW];
        assign po_arr[v] = exp_po_i[v*POW +: POW];
        for (genvar k = 0; k < CHAIN; k++) begin : g_bit
            assign vec_sh[v][k] = vec_state_i[v*CHAIN + CHAIN - 1 - k];
            assign exp_sh[v][k] = exp_state_i[v*CHAIN + CHAIN - 1 - k];
        end
    end

    logic [KW-1:0]  kidx;
    logic [CW-1:0]  fl_age;
    logic [VIW-1:0] prev_v;
    logic           mism;
    logic [VW-1:0]  mism_idx;

    assign kidx   = r_q.cnt[KW-1:0];
    assign fl_age = r_q.cnt - CW'(CHAIN);
    assign prev_v = r_q.vidx - VIW'(1);

    always_comb begin
        r_d         = r_q;
        scan_mode_o = 1'b1;
        sdi_o       = 1'b0;
        pi_o        = pi_arr[r_q.vidx];
        mism        = 1'b0;
        mism_idx    = '0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.phase = PH_FLUSH;
                    r_d.cnt   = '0;
                    r_d.vidx  = '0;
                    r_d.fail  = 1'b0;
                    r_d.fidx  = '0;
                    r_d.done  = 1'b0;
                end
            end
            PH_FLUSH: begin
                // R2: pattern 0,0,1,1,... and compare after CHAIN cycles
                sdi_o = r_q.cnt[1];
                if (r_q.cnt >= CW'(CHAIN)) begin
                    mism     = (sdo_i != fl_age[1]);
                    mism_idx = VW'(NVEC);
                end
                if (r_q.cnt == CW'(2 * CHAIN - 1)) begin
                    r_d.phase = PH_LOAD;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            PH_LOAD: begin
                // R3 load, R5 overlapped unload of the previous response
                sdi_o = vec_sh[r_q.vidx][kidx];
                if (r_q.vidx != '0) begin
                    mism     = (sdo_i != exp_sh[prev_v][kidx]);
                    mism_idx = VW'(prev_v);
                end
                if (r_q.cnt == CW'(CHAIN - 1)) begin
                    r_d.phase = PH_CAPT;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            PH_CAPT: begin
                // R4: one functional clock, outputs checked before it
                scan_mode_o = 1'b0;
                mism        = (po_i != po_arr[r_q.vidx]);
                mism_idx    = VW'(r_q.vidx);
                if (r_q.vidx == VIW'(NVEC - 1)) begin
                    r_d.phase = PH_UNLOAD;
                end else begin
                    r_d.phase = PH_LOAD;
                    r_d.vidx  = r_q.vidx + VIW'(1);
                end
                r_d.cnt = '0;
            end
            PH_UNLOAD: begin
                // R5: final unload with zeros shifted in
                mism     = (sdo_i != exp_sh[VIW'(NVEC - 1)][kidx]);
                mism_idx = VW'(NVEC - 1);
                if (r_q.cnt == CW'(CHAIN - 1)) begin
                    r_d.phase = PH_IDLE;
                    r_d.done  = 1'b1;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
        // R7: first mismatch wins
        if (mism && !r_q.fail) begin
            r_d.fail = 1'b1;
            r_d.fidx = mism_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o     = r_q.done;
    assign fail_o     = r_q.fail;
    assign fail_vec_o = r_q.fidx;

    p_capture_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_CAPT) |=> (r_q.phase != PH_CAPT));
    p_load_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_LOAD && r_q.cnt == '0)
            |-> ($past(r_q.phase) == PH_FLUSH || $past(r_q.phase) == PH_CAPT));
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fail && !(r_q.phase == PH_IDLE && start_i))
            |=> (r_q.fail && $stable(r_q.fidx)));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.phase == PH_IDLE));
    p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase != PH_IDLE && r_q.phase != PH_UNLOAD) |=> (r_q.phase != PH_IDLE));
endmodule

// File: rtl/fscan_seq.sv
module fscan_seq #(
    parameter int CHAIN = 8,
    parameter int NVEC  = 6,
    parameter int PIW   = 4,
    parameter int POW   = 4,
    localparam int VW   = $clog2(NVEC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [NVEC*CHAIN-1:0] vec_state_i,
    input  logic [NVEC*PIW-1:0]   vec_pi_i,
    input  logic [NVEC*CHAIN-1:0] exp_state_i,
    input  logic [NVEC*POW-1:0]   exp_po_i,
    output logic                  scan_mode_o,
    output logic                  scan_in_o,
    output logic                  scan_out_o,
    output logic [PIW-1:0]        pi_o,
    output logic [POW-1:0]        po_o,
    output logic                  done_o,
    output logic                  fail_o,
    output logic [VW-1:0]         fail_vec_o
);
    logic [CHAIN-1:0] state_w;
    logic [CHAIN-1:0] func_w;

    fscan_ctrl #(.CHAIN(CHAIN), .NVEC(NVEC), .PIW(PIW), .POW(POW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .vec_state_i (vec_state_i),
        .vec_pi_i    (vec_pi_i),
        .exp_state_i (exp_state_i),
        .exp_po_i    (exp_po_i),
        .sdo_i       (scan_out_o),
        .po_i        (po_o),
        .scan_mode_o (scan_mode_o),
        .sdi_o       (scan_in_o),
        .pi_o        (pi_o),
        .done_o      (done_o),
        .fail_o      (fail_o),
        .fail_vec_o  (fail_vec_o)
    );

    fscan_chain #(.CHAIN(CHAIN)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_mode_i (scan_mode_o),
        .sdi_i       (scan_in_o),
        .func_i      (func_w),
        .state_o     (state_w)
    );

    fscan_logic #(.CHAIN(CHAIN), .PIW(PIW), .POW(POW)) u_logic (
        .state_i (state_w),
        .pi_i    (pi_o),
        .next_o  (func_w),
        .po_o    (po_o)
    );

    assign scan_out_o = state_w[CHAIN-1];
endmodule

// File: tb/fscan_seq_bench.sv
module fscan_seq_bench;
    localparam int CHAIN = 8;
    localparam int NVEC  = 6;
    localparam int PIW   = 4;
    localparam int POW   = 4;
    localparam int VW    = $clog2(NVEC + 1);
    localparam int RUNT  = 2*CHAIN + NVEC*(CHAIN+1) + CHAIN;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [NVEC*CHAIN-1:0] vec_state = '0;
    logic [NVEC*PIW-1:0]   vec_pi = '0;
    logic [NVEC*CHAIN-1:0] exp_state = '0;
    logic [NVEC*POW-1:0]   exp_po = '0;
    logic                  scan_mode, scan_in, scan_out, done, fail;
    logic [PIW-1:0]        pi;
    logic [POW-1:0]        po;
    logic [VW-1:0]         fail_vec;

    fscan_seq #(.CHAIN(CHAIN), .NVEC(NVEC), .PIW(PIW), .POW(POW)) u_fscan_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .vec_state_i(vec_state), .vec_pi_i(vec_pi),
        .exp_state_i(exp_state), .exp_po_i(exp_po),
        .scan_mode_o(scan_mode), .scan_in_o(scan_in), .scan_out_o(scan_out),
        .pi_o(pi), .po_o(po), .done_o(done), .fail_o(fail), .fail_vec_o(fail_vec)
    );

    always #10ns clk = ~clk;

    int n_total = 0;
    int n_bad   = 0;

    logic [CHAIN-1:0] bvec [NVEC];
    logic [PIW-1:0]   bpi  [NVEC];
    logic [CHAIN-1:0] bres [NVEC];
    logic [POW-1:0]   bpo  [NVEC];
    logic [CHAIN-1:0] cor_st [NVEC];
    logic [POW-1:0]   cor_po [NVEC];

    int e_flush, e_load, e_capt, e_unl, n_capt;

    function automatic logic [CHAIN-1:0] m_next(logic [CHAIN-1:0] s, logic [PIW-1:0] p);
        logic [CHAIN-1:0] r;
        for (int i = 0; i < CHAIN; i++)
            r[i] = s[(i+CHAIN-1)%CHAIN] ^ (s[i] & s[(i+1)%CHAIN]) ^ p[i%PIW];
        return r;
    endfunction

    function automatic logic [POW-1:0] m_po(logic [CHAIN-1:0] s, logic [PIW-1:0] p);
        logic [POW-1:0] r;
        for (int j = 0; j < POW; j++)
            r[j] = s[(2*j)%CHAIN] ^ (s[(2*j+1)%CHAIN] & p[j%PIW]);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode: 0 random, 1 all zero, 2 all ones
    task automatic build(input int mode);
        for (int v = 0; v < NVEC; v++) begin
            if (mode == 0) begin
                bvec[v] = CHAIN'($urandom);
                bpi[v]  = PIW'($urandom);
            end else if (mode == 1) begin
                bvec[v] = '0; bpi[v] = '0;
            end else begin
                bvec[v] = '1; bpi[v] = '1;
            end
            bres[v]   = m_next(bvec[v], bpi[v]);
            bpo[v]    = m_po(bvec[v], bpi[v]);
            cor_st[v] = '0;
            cor_po[v] = '0;
        end
    endtask

    task automatic pack();
        vec_state = '0; vec_pi = '0; exp_state = '0; exp_po = '0;
        for (int v = 0; v < NVEC; v++) begin
            vec_state = vec_state | ((NVEC*CHAIN)'(bvec[v]) << (v*CHAIN));
            vec_pi    = vec_pi    | ((NVEC*PIW)'(bpi[v]) << (v*PIW));
            exp_state = exp_state | ((NVEC*CHAIN)'(bres[v] ^ cor_st[v]) << (v*CHAIN));
            exp_po    = exp_po    | ((NVEC*POW)'(bpo[v] ^ cor_po[v]) << (v*POW));
        end
    endtask

    task automatic observe(input int t);
        int u, w, v, k;
        u = t - 1;
        if (!scan_mode) n_capt++;
        if (u < 2*CHAIN) begin
            if (scan_mode !== 1'b1 || scan_in !== 1'(((u >> 1) & 1))) e_flush++;
        end else begin
            w = u - 2*CHAIN;
            v = w / (CHAIN+1);
            k = w % (CHAIN+1);
            if (v < NVEC) begin
                if (k < CHAIN) begin
                    if (scan_mode !== 1'b1 || scan_in !== bvec[v][CHAIN-1-k]) e_load++;
                    if (v >= 1 && scan_out !== bres[v-1][CHAIN-1-k]) e_unl++;
                end else begin
                    if (scan_mode !== 1'b0 || pi !== bpi[v] || po !== bpo[v]) e_capt++;
                end
            end else begin
                k = w - NVEC*(CHAIN+1);
                if (scan_mode !== 1'b1 || scan_in !== 1'b0 ||
                    scan_out !== bres[NVEC-1][CHAIN-1-k]) e_unl++;
            end
        end
    endtask

    task automatic run(input int poke_at, output int t_done);
        e_flush = 0; e_load = 0; e_capt = 0; e_unl = 0; n_capt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        t_done = 0;
        for (int t = 1; t <= 200; t++) begin
            if (t > 1) @(negedge clk);
            start = (t == poke_at);
            if (done) begin t_done = t; break; end
            observe(t);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int td;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 fail after reset", int'(fail), 0);
        check("R1 fail index after reset", int'(fail_vec), 0);
        check("R1 idle scan mode", int'(scan_mode), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // clean random run
        build(0); pack();
        run(0, td);
        check("R2 flush pattern", e_flush, 0);
        check("R3 load order", e_load, 0);
        check("R4 capture cycle pi/po", e_capt, 0);
        check("R9 example logic response", e_unl, 0);
        check("R6 done cycle", td, RUNT + 1);
        check("R6 capture count", n_capt, NVEC);
        check("R7 clean run fail", int'(fail), 0);
        repeat (5) @(negedge clk);
        check("R8 done holds", int'(done), 1);

        // wrong expected primary output for vector 3
        cor_po[3] = POW'(1); pack();
        run(0, td);
        check("R7 po mismatch flag", int'(fail), 1);
        check("R7 po mismatch index", int'(fail_vec), 3);
        check("R6 done cycle with failure", td, RUNT + 1);

        // wrong expected state for vectors 2 and 4: first one wins
        cor_po[3] = '0; cor_st[2] = CHAIN'(1) << (CHAIN-1); cor_st[4] = CHAIN'(1); pack();
        run(0, td);
        check("R5 overlapped unload mismatch flag", int'(fail), 1);
        check("R7 first failure index kept", int'(fail_vec), 2);

        // final unload compares last response
        cor_st[2] = '0; cor_st[4] = '0; cor_st[NVEC-1] = CHAIN'(4); pack();
        run(0, td);
        check("R5 final unload mismatch flag", int'(fail), 1);
        check("R5 final unload index", int'(fail_vec), NVEC-1);

        // new random, clean, with start pulsed mid-run
        build(0); pack();
        run(20, td);
        check("R8 restart clears fail", int'(fail), 0);
        check("R8 busy start ignored", td, RUNT + 1);
        check("R8 busy start run order", e_flush + e_load + e_capt + e_unl, 0);

        // directed corner vectors
        for (int m = 1; m <= 2; m++) begin
            build(m); pack();
            run(0, td);
            check("R10 corner vector chain behaviour", e_load + e_capt + e_unl, 0);
            check("R4 corner vector fail", int'(fail), 0);
        end

        // several more random clean runs
        for (int n = 0; n < 4; n++) begin
            build(0); pack();
            run(0, td);
            check("R9 random logic response", e_capt + e_unl, 0);
            check("R7 random clean fail", int'(fail), 0);
        end

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule